// File: doc/BRIEF.md
# Delay-Slot Hazard Checker

This block watches the instruction stream of a simple pipelined processor that has no hardware interlocks. Such a processor depends on the code it runs to keep the two delay slots it exposes. One is the slot after a memory load, whose destination is not yet valid. The other is the slot after an arithmetic result, which a store cannot yet pick up as its data. The checker receives one issued instruction per clock cycle: a 3-bit operation class, a destination index and two source indices. There is no handshake, and an idle cycle is issued as a no-operation.

The checker remembers what the previous instruction left pending. It classifies the current instruction against that state and reports any broken rule one cycle later as a violation flag and a 2-bit code. The checker only observes the stream. It never stalls, reorders or executes anything. Register index 0 is the constant-zero register. Writing to it discards the result, so an instruction with destination 0, such as a compare written as a subtract into register 0, leaves nothing pending.

Top module: `hz_slot_checker`

## Requirements
- R1: The reset is synchronous and active high. After reset `viol_o` is 0 and `viol_code_o` is 0. The first instruction issued after reset is never flagged, whatever was pending before reset.
- R2: The verdict for the instruction issued in a cycle appears after the next rising clock edge and holds for exactly one cycle. `viol_o` is 1 exactly when `viol_code_o` is nonzero.
- R3: Operation classes are: 0 no-op, 1 ALU (reads `src_a_i` and `src_b_i`, writes `dst_i`), 2 direct load (writes `dst_i`), 3 indexed load (reads `src_a_i` and `src_b_i`, writes `dst_i` from memory at their sum), 4 store (reads `src_a_i` as data), 5 branch, 6 halt, 7 reserved. Code 1 is reported when the instruction right after a class-2 or class-3 load with a nonzero destination reads or writes that destination.
- R4: Code 2 is reported when a class-2 or class-3 load directly follows a class-2 or class-3 load with a nonzero destination, and code 1 does not apply.
- R5: Code 3 is reported when a store's `src_a_i` equals the nonzero destination of the ALU instruction directly before it.
- R6: An instruction with destination 0 leaves no pending hazard, so the instruction after it is never flagged. This covers an ALU compare into register 0 and a load into register 0.
- R7: When an instruction after a load breaks both the use rule and the slot rule, code 1 is reported.
- R8: A halt (class 6) is never flagged, whatever precedes it.
- R9: No-op, store, branch, halt and reserved instructions leave no pending hazard, so the instruction after them is never flagged.
- R10: Fields an operation class does not use have no effect. Examples are `src_b_i` of a store, the sources of a direct load, and the destination of a store, branch or no-op. A read of register 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation class of the issued instruction |
| dst_i | input | 4 | Destination register index |
| src_a_i | input | 4 | First source index (store data register) |
| src_b_i | input | 4 | Second source index |
| viol_o | output | 1 | Registered violation flag |
| viol_code_o | output | 2 | Registered violation code: 0 none, 1 load use, 2 load in load slot, 3 store after write |

## Verification
Two rules can fire on the same instruction: the load-use rule and the load-slot rule. This happens when a load or indexed load directly follows a load and also reads or overwrites that load's destination. The bench sweeps every ordered pair of instructions built from all eight operation classes and register indices 0 to 2, with a no-op before each pair. Each such collision is therefore issued many times, in both direct and indexed forms. Every pair's verdict is judged against an arithmetic model in the bench, which must report code 1 where the two rules collide.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_W          = 4;
    localparam int NUM_SRC        = 2;
    localparam int OP_W           = 3;
    localparam int CODE_W         = 2;
    localparam int STORE_DATA_SRC = 0;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'd0,
        OP_ALU    = 3'd1,
        OP_LOAD   = 3'd2,
        OP_IND    = 3'd3,
        OP_STORE  = 3'd4,
        OP_BRANCH = 3'd5,
        OP_HALT   = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    typedef enum logic [CODE_W-1:0] {
        HZ_NONE      = 2'd0,
        HZ_LOAD_USE  = 2'd1,
        HZ_LOAD_SLOT = 2'd2,
        HZ_STORE_RAW = 2'd3
    } hz_code_e;

    // What one instruction touches, as seen by the rule logic.
    typedef struct packed {
        logic                    wr;
        reg_idx_t                wr_reg;
        logic [NUM_SRC-1:0]      rd_en;
        reg_idx_t [NUM_SRC-1:0]  rd_reg;
        logic                    is_load;
        logic                    is_store;
        logic                    is_alu;
        logic                    is_halt;
    } access_t;

    // What the previous instruction left behind.
    typedef struct packed {
        logic     load_pend;
        logic     alu_pend;
        reg_idx_t reg_idx;
    } pend_t;

    function automatic logic op_writes(op_e op);
        case (op)
            OP_ALU, OP_LOAD, OP_IND: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_load(op_e op);
        return (op == OP_LOAD) || (op == OP_IND);
    endfunction

    function automatic logic op_reads_src(op_e op, int idx);
        case (op)
            OP_ALU, OP_IND: return 1'b1;
            OP_STORE:       return idx == STORE_DATA_SRC;
            default:        return 1'b0;
        endcase
    endfunction

    function automatic logic reg_live(reg_idx_t r);
        return r != '0;
    endfunction

endpackage

// File: rtl/hz_decode.sv
module hz_decode
    import hz_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  op_e                   op,
    input  reg_idx_t              dst,
    input  reg_idx_t [N_SRC-1:0]  src,
    output access_t               acc
);

    logic [N_SRC-1:0]     rd_en_w;
    reg_idx_t [N_SRC-1:0] rd_reg_w;

    // A read of the zero register can never collide, so it is not enabled.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        assign rd_en_w[s]  = op_reads_src(op, s) && reg_live(src[s]);
        assign rd_reg_w[s] = src[s];
    end

    always_comb begin
        acc          = '0;
        acc.wr       = op_writes(op);
        acc.wr_reg   = op_writes(op) ? dst : '0;
        acc.rd_en    = rd_en_w;
        acc.rd_reg   = rd_reg_w;
        acc.is_load  = op_is_load(op);
        acc.is_store = (op == OP_STORE);
        acc.is_alu   = (op == OP_ALU);
        acc.is_halt  = (op == OP_HALT);
    end

endmodule

// File: rtl/hz_history.sv
module hz_history
    import hz_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    output pend_t   pend
);

    logic live_dst;
    assign live_dst = acc.wr && reg_live(acc.wr_reg);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend.load_pend <= live_dst && acc.is_load;
            pend.alu_pend  <= live_dst && acc.is_alu;
            pend.reg_idx   <= live_dst ? acc.wr_reg : '0;
        end
    end

    // R6: a write to the zero register leaves nothing pending
    assert_zero_dst_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.wr_reg == '0) |=> !(pend.load_pend || pend.alu_pend));

    // R9: instructions that write nothing clear the pending state
    assert_no_write_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !acc.wr |=> !(pend.load_pend || pend.alu_pend));

endmodule

// File: rtl/hz_rules.sv
module hz_rules
    import hz_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  pend_t    pend,
    input  access_t  acc,
    output logic     hit_any,
    output hz_code_e code
);

    logic [N_SRC-1:0] src_hit;

    for (genvar s = 0; s < N_SRC; s++) begin : g_use
        assign src_hit[s] = acc.rd_en[s] && (acc.rd_reg[s] == pend.reg_idx);
    end

    logic use_hit, slot_hit, raw_hit;

    always_comb begin
        use_hit  = pend.load_pend && ((|src_hit) ||
                   (acc.wr && acc.wr_reg == pend.reg_idx));
        slot_hit = pend.load_pend && acc.is_load;
        raw_hit  = pend.alu_pend && acc.is_store && src_hit[STORE_DATA_SRC];
        if (acc.is_halt) begin
            use_hit  = 1'b0;
            slot_hit = 1'b0;
            raw_hit  = 1'b0;
        end
    end

    always_comb begin
        if (use_hit)       code = HZ_LOAD_USE;
        else if (slot_hit) code = HZ_LOAD_SLOT;
        else if (raw_hit)  code = HZ_STORE_RAW;
        else               code = HZ_NONE;
    end

    assign hit_any = use_hit | slot_hit | raw_hit;

endmodule

// File: rtl/hz_slot_checker.sv
module hz_slot_checker
    import hz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic [REG_W-1:0] src_a_i,
    input  logic [REG_W-1:0] src_b_i,
    output logic             viol_o,
    output logic [CODE_W-1:0] viol_code_o
);

    op_e                    op_w;
    reg_idx_t [NUM_SRC-1:0] src_w;
    access_t                acc_w;
    pend_t                  pend_w;
    logic                   hit_w;
    hz_code_e               code_w;

    assign op_w     = op_e'(op_i);
    assign src_w[0] = src_a_i;
    assign src_w[1] = src_b_i;

    hz_decode #(.N_SRC(NUM_SRC)) u_decode (
        .op  (op_w),
        .dst (dst_i),
        .src (src_w),
        .acc (acc_w)
    );

    hz_history u_history (
        .clk  (clk),
        .rst  (rst),
        .acc  (acc_w),
        .pend (pend_w)
    );

    hz_rules #(.N_SRC(NUM_SRC)) u_rules (
        .pend    (pend_w),
        .acc     (acc_w),
        .hit_any (hit_w),
        .code    (code_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_o      <= 1'b0;
            viol_code_o <= '0;
        end else begin
            viol_o      <= hit_w;
            viol_code_o <= code_w;
        end
    end

    // R1: first instruction after reset is never flagged
    assert_first_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> !viol_o);

    // R2: flag and code agree (separate registers fed by separate logic)
    assert_flag_code_R2: assert property (@(posedge clk) disable iff (rst)
        viol_o == (viol_code_o != HZ_NONE));

    // R8: halt never flagged
    assert_halt_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (op_w == OP_HALT) |=> !viol_o);

    // R9: instruction after a no-op never flagged
    assert_after_nop_R9: assert property (@(posedge clk) disable iff (rst)
        (op_w == OP_NOP) |=> ##1 !viol_o);

    // R5: store-after-write code only on a store
    assert_raw_on_store_R5: assert property (@(posedge clk) disable iff (rst)
        (viol_code_o == HZ_STORE_RAW) |-> ($past(op_w) == OP_STORE));

    // R4: slot code only on a load
    assert_slot_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        (viol_code_o == HZ_LOAD_SLOT) |-> ($past(op_w) == OP_LOAD || $past(op_w) == OP_IND));

endmodule

// File: tb/test_hz_slot_checker.sv
`timescale 1ns/1ps
module test_hz_slot_checker;

    localparam int C_NOP = 0, C_ALU = 1, C_LD = 2, C_IND = 3, C_ST = 4, C_HALT = 6;
    localparam int NREG = 3;
    localparam int NINS = 8 * NREG * NREG * NREG;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op_i;
    logic [3:0] dst_i, src_a_i, src_b_i;
    logic       viol_o;
    logic [1:0] viol_code_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hz_slot_checker i_hz_slot_checker (
        .clk(clk), .rst(rst), .op_i(op_i), .dst_i(dst_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i),
        .viol_o(viol_o), .viol_code_o(viol_code_o)
    );

    // Expected code from the rules, given previous and current instruction.
    function automatic int exp_code(int pop, int pd, int cop, int cd, int ca, int cb);
        bit prev_load = (pop == C_LD || pop == C_IND) && pd != 0;
        bit prev_alu  = (pop == C_ALU) && pd != 0;
        bit uses = 0;
        bit writes;
        if (cop == C_ALU || cop == C_IND) uses = (ca == pd) || (cb == pd);
        else if (cop == C_ST)             uses = (ca == pd);
        writes = (cop == C_ALU || cop == C_LD || cop == C_IND) && cd == pd;
        if (cop == C_HALT) return 0;
        if (prev_load && (uses || writes)) return 1;
        if (prev_load && (cop == C_LD || cop == C_IND)) return 2;
        if (prev_alu && cop == C_ST && ca == pd) return 3;
        return 0;
    endfunction

    task automatic issue(input int op, input int d, input int a, input int b);
        @(negedge clk);
        op_i = op[2:0]; dst_i = d[3:0]; src_a_i = a[3:0]; src_b_i = b[3:0];
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int exp, input string tag);
        checks++;
        if (int'(viol_code_o) != exp || viol_o != (exp != 0)) begin
            errors++;
            if (errors <= 20)
                $display("FAIL %s: code=%0d flag=%0b expected code=%0d flag=%0b",
                         tag, viol_code_o, viol_o, exp, (exp != 0));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_i = 0; dst_i = 0; src_a_i = 0; src_b_i = 0;
        repeat (3) @(posedge clk);
        #1;
        check(0, "R1 reset state");
        @(negedge clk); rst = 1'b0;

        // R1: pending load cleared by reset
        issue(C_LD, 1, 0, 0);
        @(negedge clk); rst = 1'b1; op_i = C_ALU; dst_i = 2; src_a_i = 1; src_b_i = 1;
        @(posedge clk); #1;
        check(0, "R1 outputs during reset");
        @(negedge clk); rst = 1'b0;
        issue(C_ALU, 2, 1, 1);
        check(0, "R1 first after reset");

        // R2: chained stream without separators
        issue(C_LD, 1, 0, 0);   check(0, "R2 chain load");
        issue(C_IND, 1, 2, 0);  check(1, "R7 chain ind on load dst");
        issue(C_ALU, 2, 0, 1);  check(1, "R3 chain use after ind");
        issue(C_ST, 0, 2, 0);   check(3, "R5 chain store after alu");
        issue(C_NOP, 0, 0, 0);  check(0, "R2 verdict lasts one cycle");

        // Exhaustive pair sweep with a no-op before each pair
        for (int i = 0; i < NINS; i++) begin
            int ao = i / 27, ad = (i / 9) % 3, aa = (i / 3) % 3, ab = i % 3;
            for (int j = 0; j < NINS; j++) begin
                int bo = j / 27, bd = (j / 9) % 3, ba = (j / 3) % 3, bb = j % 3;
                int e;
                string tag;
                issue(C_NOP, 0, 0, 0);
                issue(ao, ad, aa, ab);
                check(0, "R9 after nop");
                issue(bo, bd, ba, bb);
                e = exp_code(ao, ad, bo, bd, ba, bb);
                if (e == 1 && (bo == C_LD || bo == C_IND)) tag = "R7 pair";
                else if (e == 1) tag = "R3 pair";
                else if (e == 2) tag = "R4 pair";
                else if (e == 3) tag = "R5 pair";
                else if (bo == C_HALT) tag = "R8 pair";
                else if (ad == 0) tag = "R6 pair";
                else tag = "R10 pair";
                check(e, tag);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule